// File: doc/BRIEF.md
# Vertical Retrace Interrupt Unit

This block produces the vertical-retrace interrupt of a legacy PC display controller. A level signal from the display timing chain says when vertical retrace is active. The block samples that level on the system clock and detects its rising edge. When the edge arrives and the interrupt is armed, it sets an interrupt latch. The latch drives an interrupt request line toward the system interrupt controller. Software can also read the latch as a status bit.

Software controls the unit through an 8-bit control register, reached over a small synchronous register port with an index select. Bit 4 of that register arms the latch. Writing bit 4 as zero clears the latch and keeps it clear. Bit 5 is an active-high disable: it stops the latch from setting and masks the request line, but it leaves a latch that is already set untouched. The latch appears on bit 7 of a status register. A mode pin picks the polarity of that bit so that both the older and the newer adapter families are served.

Top module: `vretrace_irq`

## Requirements
- R1: The latch sets on the rising edge of `vretrace_in` after a synchronizer of SYNC_STAGES flops, so it is visible SYNC_STAGES+1 rising clock edges after the input rises. A retrace level held high for many cycles sets the latch once only: if the latch is cleared and re-armed while retrace stays high, it stays clear.
- R2: The latch can set only when the stored control register already holds bit 4 = 1 and bit 5 = 0 in the cycle of the rising edge.
- R3: A write to index 0 with bit 4 = 0 clears the latch at that clock edge. The latch stays clear for as long as stored bit 4 is 0.
- R4: Once set, the latch keeps its value when retrace ends. It changes only when bit 4 is written as 0.
- R5: `irq_out` is 1 exactly when the latch is set and stored bit 5 is 0. Writing bit 5 = 1 masks `irq_out` but does not clear the latch, so clearing bit 5 again brings the request back.
- R6: Reading index 1 returns the latch on bit 7 and zeros on bits 6..0. With `legacy_mode` = 0 bit 7 equals the latch. With `legacy_mode` = 1 bit 7 is the inverse of the latch.
- R7: After reset the control register is 0x00, the latch is clear and `irq_out` is 0.
- R8: If a write that clears bit 4 falls in the same cycle as a detected retrace rising edge, the clear wins and the latch ends up clear.
- R9: Reading index 0 returns all 8 stored control bits. Indexes other than 0 and 1 read as 0x00. Reads never change the latch or the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vretrace_in | input | 1 | Vertical retrace level from the timing chain |
| legacy_mode | input | 1 | 1 selects inverted status polarity (older adapter family) |
| reg_sel | input | IDX_W | Register index: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe, applies `reg_wdata` to the selected index at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the index on `reg_sel` (combinational) |
| irq_out | output | 1 | Interrupt request to the system interrupt controller |

## Verification
Two things can land on the same clock edge: a software write that clears bit 4, and a detected retrace rising edge. The bench provokes this on purpose. It raises retrace and then issues the clearing write in the exact cycle the synchronized edge reaches the latch. It then re-arms while retrace is still high and expects the latch to stay clear, because the clear must win and no second edge must appear. The random phase keeps both events coming: writes and slow retrace toggles overlap many times. Every cycle is judged against a cycle-accurate reference model kept in the bench.

// File: rtl/vri_pkg.sv
// Package: shared constants for the vertical retrace interrupt unit.
// Assumes an 8-bit register port; bit positions are fixed by software use.
package vri_pkg;
    localparam int DATA_W   = 8;
    localparam int ARM_BIT  = 4;   // 1 arms the latch, 0 clears it
    localparam int MASK_BIT = 5;   // 1 disables set and masks the request
    localparam int STAT_BIT = 7;   // status position of the latch
    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;

    typedef logic [DATA_W-1:0] reg_word_t;
endpackage

// File: rtl/vri_retrace_edge.sv
// Module: synchronizes the retrace level into the clock domain and
// detects its rising edge. Assumes STAGES >= 1. Output is a one-cycle pulse.
module vri_retrace_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] stage_q;

    // Stage 0 captures the raw level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= level_in;
    end

    // Remaining synchronizer stages plus one history flop for edge detection.
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    // Rising edge: synchronized level high, previous sample low.
    always_comb rise_o = stage_q[LAST] & ~stage_q[STAGES];
endmodule

// File: rtl/vri_ctrl_reg.sv
// Module: holds the control register and exposes the value that bit 4
// will have after the current cycle's write, so a clear acts at once.
module vri_ctrl_reg #(
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     reg_sel,
    input  logic                 reg_wr,
    input  vri_pkg::reg_word_t   reg_wdata,
    output vri_pkg::reg_word_t   ctrl_q,
    output logic                 arm_next
);
    import vri_pkg::*;

    logic wr_hit;

    // Decode a write aimed at the control index.
    always_comb wr_hit = reg_wr && (reg_sel == IDX_W'(IDX_CTRL));

    // Arm value after this edge; a write of 0 clears immediately.
    always_comb arm_next = wr_hit ? reg_wdata[ARM_BIT] : ctrl_q[ARM_BIT];

    // Store written control bits; reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_hit) ctrl_q <= reg_wdata;
    end
endmodule

// File: rtl/vri_irq_latch.sv
// Module: the interrupt latch and masked request output. Assumes rise_i is
// a single-cycle pulse. A clear always takes priority over a set.
module vri_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic arm_q,
    input  logic mask_q,
    input  logic arm_next,
    output logic latch_q,
    output logic irq_o
);
    logic set_ok;

    // Set only with the stored register armed and not disabled.
    always_comb set_ok = rise_i & arm_q & ~mask_q;

    // Latch update: clear dominates, otherwise sticky set.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (!arm_next) latch_q <= 1'b0;
        else if (set_ok)   latch_q <= 1'b1;
    end

    // Request leaves the block unless masked by the disable bit.
    always_comb irq_o = latch_q & ~mask_q;
endmodule

// File: rtl/vri_readback.sv
// Module: read multiplexer for control and status. Purely combinational,
// so a read can never disturb state.
module vri_readback #(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0]   reg_sel,
    input  logic               legacy_mode,
    input  logic               latch_q,
    input  vri_pkg::reg_word_t ctrl_q,
    output vri_pkg::reg_word_t reg_rdata
);
    import vri_pkg::*;

    reg_word_t status_w;

    // Build status word with mode-dependent polarity on the latch bit.
    always_comb begin
        status_w           = '0;
        status_w[STAT_BIT] = legacy_mode ? ~latch_q : latch_q;
    end

    // Select the addressed register; unused indexes read zero.
    always_comb begin
        if (reg_sel == IDX_W'(IDX_CTRL))      reg_rdata = ctrl_q;
        else if (reg_sel == IDX_W'(IDX_STAT)) reg_rdata = status_w;
        else                                  reg_rdata = '0;
    end
endmodule

// File: rtl/vretrace_irq.sv
// Top: vertical retrace interrupt unit. Synchronizes retrace, holds the
// control register, keeps the interrupt latch and serves register reads.
// Assumes a synchronous active-low reset and a single clock domain.
module vretrace_irq #(
    parameter int IDX_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vretrace_in,
    input  logic             legacy_mode,
    input  logic [IDX_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq_out
);
    import vri_pkg::*;

    logic      edge_rise;
    logic      arm_next;
    logic      latch_q;
    reg_word_t ctrl_q;

    vri_retrace_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (vretrace_in),
        .rise_o   (edge_rise)
    );

    vri_ctrl_reg #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ctrl_q    (ctrl_q),
        .arm_next  (arm_next)
    );

    vri_irq_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (edge_rise),
        .arm_q    (ctrl_q[ARM_BIT]),
        .mask_q   (ctrl_q[MASK_BIT]),
        .arm_next (arm_next),
        .latch_q  (latch_q),
        .irq_o    (irq_out)
    );

    vri_readback #(.IDX_W(IDX_W)) u_rd (
        .reg_sel     (reg_sel),
        .legacy_mode (legacy_mode),
        .latch_q     (latch_q),
        .ctrl_q      (ctrl_q),
        .reg_rdata   (reg_rdata)
    );
endmodule

// File: rtl/vri_checker.sv
// Checker: temporal properties of the retrace interrupt unit, bound to the top.
module vri_checker #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             latch_q,
    input logic [7:0]       ctrl_q,
    input logic             legacy_mode,
    input logic [IDX_W-1:0] reg_sel,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             irq_out
);
    // R1
    latch_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> $past(rise));

    // R2
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> ($past(ctrl_q[4]) && !$past(ctrl_q[5])));

    // R3
    disarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[4] |-> !latch_q);

    // R4
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q |=> (latch_q || !ctrl_q[4]));

    // R5
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[5] |-> !irq_out);

    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> latch_q);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && reg_wr && reg_sel == IDX_W'(0) && !reg_wdata[4]) |=> !latch_q);

    // R6
    status_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == IDX_W'(1)) |-> (reg_rdata[7] == (legacy_mode ? !latch_q : latch_q)));
endmodule

bind vretrace_irq vri_checker #(.IDX_W(IDX_W)) u_vri_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (edge_rise),
    .latch_q     (latch_q),
    .ctrl_q      (ctrl_q),
    .legacy_mode (legacy_mode),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_out     (irq_out)
);

// File: tb/test_vretrace_irq.sv
module test_vretrace_irq;
    localparam int N = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vr = 1'b0;
    logic       lg = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [N:0] m_pipe = '0;
    logic [7:0] m_ctrl = 8'h00;
    logic       m_latch = 1'b0;

    always #10 clk = ~clk;

    vretrace_irq #(.IDX_W(2), .SYNC_STAGES(N)) i_vretrace_irq (
        .clk(clk), .rst_n(rst_n), .vretrace_in(vr), .legacy_mode(lg),
        .reg_sel(sel), .reg_wr(wr), .reg_wdata(wd), .reg_rdata(rdata),
        .irq_out(irq)
    );

    // Reference model, built from the requirements.
    always @(posedge clk) begin
        logic rise, arm_nx;
        if (!rst_n) begin
            m_pipe = '0; m_ctrl = 8'h00; m_latch = 1'b0;
        end else begin
            rise   = m_pipe[N-1] & ~m_pipe[N];
            arm_nx = (wr && sel == 2'd0) ? wd[4] : m_ctrl[4];
            if (!arm_nx) m_latch = 1'b0;
            else if (rise && m_ctrl[4] && !m_ctrl[5]) m_latch = 1'b1;
            if (wr && sel == 2'd0) m_ctrl = wd;
            m_pipe = {m_pipe[N-1:0], vr};
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] s, input logic l);
        case (s)
            2'd0:    return m_ctrl;
            2'd1:    return {(l ? ~m_latch : m_latch), 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, let the edge pass, compare at next negedge.
    task automatic cyc(input bit w, input logic [1:0] s, input logic [7:0] d,
                       input bit v, input bit l);
        wr = w; sel = s; wd = d; vr = v; lg = l;
        @(posedge clk);
        @(negedge clk);
        chk("R5 irq vs model", {7'b0, irq}, {7'b0, m_latch & ~m_ctrl[5]});
        chk(s == 2'd1 ? "R6 status vs model" : "R9 readback vs model",
            rdata, exp_rd(s, l));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        cyc(0, 2'd0, 8'h00, 0, 0);
        chk("R7 ctrl reset", rdata, 8'h00);
        chk("R7 irq reset", {7'b0, irq}, 8'h00);
        cyc(0, 2'd1, 8'h00, 0, 1);
        chk("R7 legacy status after reset", rdata, 8'h80);

        // R1 latency and set
        cyc(1, 2'd0, 8'h10, 0, 0);
        cyc(0, 2'd1, 8'h00, 1, 0);
        cyc(0, 2'd1, 8'h00, 1, 0);
        chk("R1 not yet set", rdata, 8'h00);
        cyc(0, 2'd1, 8'h00, 1, 0);
        chk("R1 latch set", rdata, 8'h80);
        chk("R1 irq high", {7'b0, irq}, 8'h01);
        repeat (5) cyc(0, 2'd1, 8'h00, 1, 0);
        repeat (4) cyc(0, 2'd1, 8'h00, 0, 0);
        chk("R4 latch kept after retrace", rdata, 8'h80);

        // R5 mask keeps latch
        cyc(1, 2'd0, 8'h30, 0, 0);
        chk("R5 masked irq", {7'b0, irq}, 8'h00);
        cyc(0, 2'd1, 8'h00, 0, 0);
        chk("R5 latch kept under mask", rdata, 8'h80);
        cyc(1, 2'd0, 8'h10, 0, 0);
        chk("R5 irq back after unmask", {7'b0, irq}, 8'h01);

        // R6 legacy polarity, R9 read has no effect
        cyc(0, 2'd1, 8'h00, 0, 1);
        chk("R6 legacy inverted", rdata, 8'h00);
        cyc(0, 2'd1, 8'h00, 0, 0);
        chk("R9 status read no side effect", rdata, 8'h80);
        cyc(0, 2'd3, 8'h00, 0, 0);
        chk("R9 unused index", rdata, 8'h00);

        // R3 clear and hold
        cyc(1, 2'd0, 8'h00, 0, 0);
        chk("R3 clear irq", {7'b0, irq}, 8'h00);
        repeat (4) cyc(0, 2'd1, 8'h00, 1, 0);
        chk("R3 held clear", rdata, 8'h00);
        // R1 single set per level: re-arm while still high
        cyc(1, 2'd0, 8'h10, 1, 0);
        repeat (4) cyc(0, 2'd1, 8'h00, 1, 0);
        chk("R1 no second set on held level", rdata, 8'h00);
        repeat (4) cyc(0, 2'd1, 8'h00, 0, 0);

        // R2 disable bit blocks set
        cyc(1, 2'd0, 8'h30, 0, 0);
        repeat (4) cyc(0, 2'd1, 8'h00, 1, 0);
        repeat (4) cyc(0, 2'd1, 8'h00, 0, 0);
        chk("R2 no set while disabled", rdata, 8'h00);
        cyc(1, 2'd0, 8'h10, 0, 0);

        // R8 clear in the same cycle as the edge
        cyc(0, 2'd1, 8'h00, 1, 0);
        cyc(0, 2'd1, 8'h00, 1, 0);
        cyc(1, 2'd0, 8'h00, 1, 0);
        cyc(1, 2'd0, 8'h10, 1, 0);
        cyc(0, 2'd1, 8'h00, 1, 0);
        chk("R8 clear wins over edge", rdata, 8'h00);
        repeat (3) cyc(0, 2'd1, 8'h00, 0, 0);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            bit w, v, l;
            logic [1:0] s;
            logic [7:0] d;
            w = ($urandom_range(3) == 0);
            s = 2'($urandom_range(3));
            d = 8'($urandom);
            if ($urandom_range(3) != 0) d[5] = 1'b0;
            v = ($urandom_range(7) == 0) ? ~vr : vr;
            l = ($urandom_range(15) == 0) ? ~lg : lg;
            cyc(w, s, d, v, l);
        end
        finish_run();
    end
endmodule